// File: doc/BRIEF.md
# Configurable Shift and Rotate Unit

This block moves the bits of one data word by a variable distance in one of six ways: zero-filled shifts towards either end, shifts that copy an edge bit into the vacated positions, and circular rotations in either direction. A three-bit operation code and an unsigned shift distance go with each data word. The result has the same width as the input. The shifting logic is a logarithmic barrel: one two-way multiplexer stage for each bit of the internal distance.

Words enter and leave through valid/ready streams. The parameter `REG_OUT` decides how the output is driven:

- With `REG_OUT` set, one register sits between the shifter and the output. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its result is shown on the next cycle.
- The stage can be refilled on the same edge that its current word leaves. So `in_ready` is high whenever the stage is empty or `out_ready` is high.
- While `out_valid` is high and `out_ready` is low, the shown result stays frozen and no new word is taken.
- With `REG_OUT` clear, the block is purely combinational. Valid passes forward, ready passes backward, and the result is visible in the same cycle.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation code 000 shifts towards the MSB and writes 0 into each vacated low bit.
- R2: Operation code 001 shifts towards the LSB and writes 0 into each vacated high bit. For example, on 8 bits, 10010110 shifted by 2 gives 00100101.
- R3: Operation code 010 shifts towards the MSB and writes a copy of the original bit 0 into each vacated low bit.
- R4: Operation code 011 shifts towards the LSB and writes a copy of the original top bit into each vacated high bit.
- R5: Operation codes 100 (towards the MSB) and 101 (towards the LSB) rotate circularly, so every input bit appears in the result. The distance is taken modulo WIDTH.
- R6: A distance of 0 returns the input word unchanged, whatever the operation code.
- R7: For codes 000 to 011, a distance of WIDTH or more makes every result bit equal to the fill bit of that operation.
- R8: Codes 110 and 111 return the input word unchanged, whatever the distance.
- R9: With `REG_OUT` set, a synchronous active-high `rst` clears `out_valid` and `out_data` to 0. An accepted word's result appears with `out_valid` high one clock after acceptance.
- R10: With `REG_OUT` set, while `out_valid` is high and `out_ready` is low, `out_data` stays stable, `out_valid` stays high and `in_ready` is low.
- R11: With `REG_OUT` clear, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_data` is the result for the present inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge (used when `REG_OUT` is set) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take the input word this cycle |
| in_data | input | WIDTH | Word to shift or rotate |
| in_op | input | 3 | Operation code (see R1 to R8) |
| in_amt | input | AMT_W | Unsigned shift distance |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | WIDTH | Shifted or rotated word |

## Verification
A fault in a barrel stage affects only the words whose distance has that stage's bit set. It shows up in `out_data` on the cycle after acceptance, so the distances must cover every power of two. Other faults also show up at the outputs:

- A wrong fill choice appears only at the boundary positions, and most clearly on saturating distances.
- A wrong modulo on rotations appears only for distances of WIDTH or more.
- A fault in the valid/ready handling of the output register appears as a changed result, or a lost or duplicated word, in the first cycle of back-pressure.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [2:0] {
    OP_SHL_ZERO = 3'b000,
    OP_SHR_ZERO = 3'b001,
    OP_SHL_EDGE = 3'b010,
    OP_SHR_EDGE = 3'b011,
    OP_ROT_UP   = 3'b100,
    OP_ROT_DOWN = 3'b101,
    OP_THRU_A   = 3'b110,
    OP_THRU_B   = 3'b111
  } sru_op_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_LOW  = 2'd1,
    FILL_HIGH = 2'd2
  } sru_fill_e;

  typedef struct packed {
    logic      toward_msb;
    logic      circular;
    logic      thru;
    sru_fill_e fill;
  } sru_ctrl_t;

endpackage

// File: rtl/sru_decode.sv
module sru_decode
  import sru_pkg::*;
(
  input  logic [2:0] op_i,
  output sru_ctrl_t  ctrl_o
);
  sru_op_e op_e;
  assign op_e = sru_op_e'(op_i);

  always_comb begin
    ctrl_o = '{toward_msb: 1'b0, circular: 1'b0, thru: 1'b0, fill: FILL_ZERO};
    unique case (op_e)
      OP_SHL_ZERO: ctrl_o.toward_msb = 1'b1;
      OP_SHR_ZERO: ctrl_o.toward_msb = 1'b0;
      OP_SHL_EDGE: begin
        ctrl_o.toward_msb = 1'b1;
        ctrl_o.fill       = FILL_LOW;
      end
      OP_SHR_EDGE: ctrl_o.fill = FILL_HIGH;
      OP_ROT_UP: begin
        ctrl_o.toward_msb = 1'b1;
        ctrl_o.circular   = 1'b1;
      end
      OP_ROT_DOWN: ctrl_o.circular = 1'b1;
      default:     ctrl_o.thru = 1'b1;
    endcase
  end
endmodule

// File: rtl/sru_amount.sv
module sru_amount
  import sru_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int AMT_W = 6,
  localparam int LG   = $clog2(WIDTH)
) (
  input  logic [AMT_W-1:0] amt_i,
  input  sru_ctrl_t        ctrl_i,
  output logic [LG-1:0]    eff_o,
  output logic             sat_o
);
  always_comb begin
    eff_o = '0;
    sat_o = 1'b0;
    if (!ctrl_i.thru) begin
      if (ctrl_i.circular) begin
        eff_o = LG'(32'(amt_i) % 32'(WIDTH));
      end else if (32'(amt_i) >= 32'(WIDTH)) begin
        sat_o = 1'b1;
      end else begin
        eff_o = LG'(amt_i);
      end
    end
  end
endmodule

// File: rtl/sru_barrel.sv
module sru_barrel
  import sru_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int LG   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  sru_ctrl_t        ctrl_i,
  input  logic [LG-1:0]    eff_i,
  input  logic             sat_i,
  output logic [WIDTH-1:0] data_o
);
  logic fill_bit;
  logic [LG:0][WIDTH-1:0] stg;

  always_comb begin
    unique case (ctrl_i.fill)
      FILL_LOW:  fill_bit = data_i[0];
      FILL_HIGH: fill_bit = data_i[WIDTH-1];
      default:   fill_bit = 1'b0;
    endcase
  end

  assign stg[0] = data_i;

  for (genvar k = 0; k < LG; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [S-1:0]     in_up;
    logic [S-1:0]     in_dn;
    logic [WIDTH-1:0] moved;
    assign in_up = ctrl_i.circular ? stg[k][WIDTH-1:WIDTH-S] : {S{fill_bit}};
    assign in_dn = ctrl_i.circular ? stg[k][S-1:0] : {S{fill_bit}};
    assign moved = ctrl_i.toward_msb ? {stg[k][WIDTH-1-S:0], in_up}
                                     : {in_dn, stg[k][WIDTH-1:S]};
    assign stg[k+1] = eff_i[k] ? moved : stg[k];
  end

  assign data_o = sat_i ? {WIDTH{fill_bit}} : stg[LG];
endmodule

// File: rtl/sru_out_stage.sv
module sru_out_stage #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [WIDTH-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [WIDTH-1:0] dn_data
);
  if (REG_OUT) begin : g_reg
    logic             vld_q;
    logic [WIDTH-1:0] dat_q;
    assign up_ready = !vld_q || dn_ready;
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (up_valid && up_ready) begin
        vld_q <= 1'b1;
        dat_q <= up_data;
      end else if (dn_ready) begin
        vld_q <= 1'b0;
      end
    end
    assign dn_valid = vld_q;
    assign dn_data  = dat_q;
  end else begin : g_comb
    assign up_ready = dn_ready;
    assign dn_valid = up_valid;
    assign dn_data  = up_data;
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int AMT_W   = 6,
  parameter bit REG_OUT = 1'b1,
  localparam int LG     = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic [2:0]       in_op,
  input  logic [AMT_W-1:0] in_amt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  sru_ctrl_t        ctrl;
  logic [LG-1:0]    eff;
  logic             sat;
  logic [WIDTH-1:0] result;

  sru_decode u_decode (
    .op_i  (in_op),
    .ctrl_o(ctrl)
  );

  sru_amount #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_amount (
    .amt_i (in_amt),
    .ctrl_i(ctrl),
    .eff_o (eff),
    .sat_o (sat)
  );

  sru_barrel #(.WIDTH(WIDTH)) u_barrel (
    .data_i(in_data),
    .ctrl_i(ctrl),
    .eff_i (eff),
    .sat_i (sat),
    .data_o(result)
  );

  sru_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (result),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (out_data)
  );
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int WIDTH   = 16,
  parameter int AMT_W   = 6,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_data,
  input logic [2:0]       in_op,
  input logic [AMT_W-1:0] in_amt,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data
);
  logic acc;
  assign acc = in_valid && in_ready;

  if (REG_OUT) begin : g_reg
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R9: the cycle after a reset edge shows an empty, cleared stage
    always @(negedge clk) begin
      if (rst_seen) begin
        a_r9_reset_clears : assert (!out_valid && out_data == '0);
      end
    end

    a_r9_result_next : assert property (@(posedge clk) disable iff (rst)
      acc |=> out_valid);

    a_r6_zero_amount : assert property (@(posedge clk) disable iff (rst)
      acc && in_amt == '0 |=> out_data == $past(in_data));

    a_r8_thru_codes : assert property (@(posedge clk) disable iff (rst)
      acc && in_op[2:1] == 2'b11 |=> out_data == $past(in_data));

    a_r5_rotate_keeps_ones : assert property (@(posedge clk) disable iff (rst)
      acc && in_op[2:1] == 2'b10
      |=> $countones(out_data) == $countones($past(in_data)));

    a_r7_zero_fill_saturates : assert property (@(posedge clk) disable iff (rst)
      acc && in_op == 3'b000 && 32'(in_amt) >= 32'(WIDTH) |=> out_data == '0);

    a_r10_hold_under_stall : assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

    a_r10_no_take_under_stall : assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |-> !in_ready);
  end else begin : g_comb
    a_r11_valid_forward : assert property (@(posedge clk) disable iff (rst)
      in_valid |-> out_valid);

    a_r11_ready_backward : assert property (@(posedge clk) disable iff (rst)
      out_ready |-> in_ready);

    a_r6_zero_amount_comb : assert property (@(posedge clk) disable iff (rst)
      in_amt == '0 |-> out_data == in_data);

    a_r8_thru_codes_comb : assert property (@(posedge clk) disable iff (rst)
      in_op[2:1] == 2'b11 |-> out_data == in_data);
  end
endmodule

bind shift_rotate_unit sru_checker #(
  .WIDTH(WIDTH), .AMT_W(AMT_W), .REG_OUT(REG_OUT)
) u_sru_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_op(in_op), .in_amt(in_amt),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_shift_rotate_unit.sv
module test_shift_rotate_unit;
  localparam int W  = 16;
  localparam int AW = 6;
  localparam int CW = 8;
  localparam int CA = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          in_valid = 0, out_ready = 1;
  logic          in_ready, out_valid;
  logic [W-1:0]  in_data = '0, out_data;
  logic [2:0]    in_op = '0;
  logic [AW-1:0] in_amt = '0;

  logic          c_in_valid = 0, c_out_ready = 0;
  logic          c_in_ready, c_out_valid;
  logic [CW-1:0] c_in_data = '0, c_out_data;
  logic [2:0]    c_in_op = '0;
  logic [CA-1:0] c_in_amt = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  shift_rotate_unit #(.WIDTH(W), .AMT_W(AW), .REG_OUT(1'b1)) i_shift_rotate_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_op(in_op), .in_amt(in_amt),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  shift_rotate_unit #(.WIDTH(CW), .AMT_W(CA), .REG_OUT(1'b0)) i_shift_rotate_unit_comb (
    .clk(clk), .rst(rst), .in_valid(c_in_valid), .in_ready(c_in_ready),
    .in_data(c_in_data), .in_op(c_in_op), .in_amt(c_in_amt),
    .out_valid(c_out_valid), .out_ready(c_out_ready), .out_data(c_out_data)
  );

  function automatic logic [15:0] model(int w, logic [15:0] d, logic [2:0] op, int amt);
    logic [15:0] r = '0;
    int a = amt % w;
    for (int i = 0; i < w; i++) begin
      int up = i - amt;
      int dn = i + amt;
      case (op)
        3'd0: r[i] = (up >= 0) ? d[up] : 1'b0;
        3'd1: r[i] = (dn < w) ? d[dn] : 1'b0;
        3'd2: r[i] = (up >= 0) ? d[up] : d[0];
        3'd3: r[i] = (dn < w) ? d[dn] : d[w-1];
        3'd4: r[i] = d[(i - a + w) % w];
        3'd5: r[i] = d[(i + a) % w];
        default: r[i] = d[i];
      endcase
    end
    return r;
  endfunction

  function automatic string tag(int w, logic [2:0] op, int amt);
    if (op[2:1] == 2'b11) return "R8";
    if (amt == 0) return "R6";
    if (op[2] == 1'b0 && amt >= w) return "R7";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One accepted word on the registered instance, result checked a cycle later
  task automatic send(logic [W-1:0] d, logic [2:0] op, int amt);
    @(negedge clk);
    in_valid = 1; in_data = d; in_op = op; in_amt = AW'(amt); out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R9", 16'(out_valid), 16'd1);
    check(tag(W, op, amt), out_data, model(W, d, op, amt));
  endtask

  // Combinational instance, checked in the same cycle (R11)
  task automatic comb(logic [CW-1:0] d, logic [2:0] op, int amt, logic v, logic r);
    @(negedge clk);
    c_in_valid = v; c_in_data = d; c_in_op = op; c_in_amt = CA'(amt); c_out_ready = r;
    #1;
    check("R11", {14'd0, c_out_valid, c_in_ready}, {14'd0, v, r});
    check(tag(CW, op, amt), 16'(c_out_data), model(CW, 16'(d), op, amt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", {15'd0, out_valid}, 16'd0);
    check("R9", out_data, 16'd0);
    rst = 0;

    // directed corners
    send(16'h0096, 3'd1, 2);            // R2 narrow example widened
    send(16'h8001, 3'd0, 3);            // R1
    send(16'h8001, 3'd0, 16);           // R7
    send(16'h00F1, 3'd2, 4);            // R3 lsb=1
    send(16'h00F1, 3'd2, 63);           // R7 fill ones from lsb
    send(16'h8F00, 3'd3, 5);            // R4
    send(16'h8F00, 3'd3, 20);           // R7 fill ones from msb
    send(16'h7F00, 3'd3, 16);           // R7 fill zeros
    send(16'hC003, 3'd4, 1);            // R5
    send(16'hC003, 3'd5, 17);           // R5 modulo
    send(16'h1234, 3'd4, 16);           // R5 full turn
    for (int op = 0; op < 6; op++) send(16'hA5C3, 3'(op), 0);   // R6
    send(16'hBEEF, 3'd6, 9);            // R8
    send(16'hBEEF, 3'd7, 63);           // R8

    // R10: back-pressure holds the result and refuses new words
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_data = 16'h0F0F; in_op = 3'd4; in_amt = 6'd4;
    @(negedge clk);
    in_data = 16'h3C00; in_op = 3'd1; in_amt = 6'd2;
    check("R10", {15'd0, in_ready}, 16'd0);
    @(negedge clk);
    check("R10", {15'd0, out_valid}, 16'd1);
    check("R10", out_data, model(W, 16'h0F0F, 3'd4, 4));
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R10", out_data, model(W, 16'h3C00, 3'd1, 2));
    @(negedge clk);
    check("R9", {15'd0, out_valid}, 16'd0);

    // random traffic on the registered instance
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 7);
      int amt = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 63) : $urandom_range(0, 16);
      send(W'($urandom), 3'(op), amt);
    end

    // combinational instance
    comb(8'b1001_0110, 3'd1, 2, 1, 1);  // R2: 10010110 -> 00100101
    comb(8'h81, 3'd2, 3, 1, 0);         // R3
    comb(8'h81, 3'd3, 9, 0, 1);         // R7
    comb(8'h81, 3'd5, 9, 1, 1);         // R5
    for (int n = 0; n < 150; n++) begin
      comb(CW'($urandom), 3'($urandom_range(0, 7)), $urandom_range(0, 15),
           1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule